// File: doc/BRIEF.md
# Vector loop predicate generator

This block turns two scalar operands, a running start value and a limit, into a per-element loop-control predicate for a fixed-length vector unit. Element `e` is given the counter value `start + e`. That value is compared with the limit under one of four compare modes. A running AND of the results means that the active elements always form an unbroken prefix starting at element 0. The block also returns the four condition flags that describe the predicate it produced. The flags are evaluated as if every lane were governed.

Operands may be taken as 32-bit or 64-bit values. The per-element counter wraps inside the selected width. After each wrap it is read again as signed, so a counter that steps past the largest positive value becomes negative for the signed modes.

The parameter `ITERATIVE` selects the implementation. With `ITERATIVE = 0`, a single-pass comparator array produces the whole predicate. With `ITERATIVE = 1`, one shared comparator walks the elements one per clock. Both variants sit behind the same start/done handshake.

Top module: `loop_pred_gen`

## Requirements
- R1: `mode_i` selects the element test `cnt OP limit`: 2'b00 signed less-than, 2'b01 signed less-or-equal, 2'b10 unsigned lower, 2'b11 unsigned lower-or-same.
- R2: With `wide_i` = 0, only bits 31:0 of both operands take part, and bit 31 is the sign for the signed modes. Bits 63:32 have no effect on any output. With `wide_i` = 1, all 64 bits take part and bit 63 is the sign.
- R3: Element `e` uses the counter `(start + e) mod 2^W`, where W is 32 or 64. In the signed modes the wrapped bits are read as a two's complement W-bit number. For example, a 32-bit start of 0x7ffffffd with a limit of 0x7fffffff under signed less-or-equal makes all 16 byte elements active.
- R4: An element is active only if its own test passes and every lower element is active. Once an element fails, all higher elements stay inactive even where their own test would pass.
- R5: `esize_i` gives the element size as 2'b00 byte, 2'b01 halfword, 2'b10 word, 2'b11 doubleword. The element count is `VLEN_BITS/8 >> esize_i`. `pred_o` has one bit per vector byte. Element `e` is shown at bit `e << esize_i`, and every other bit is 0.
- R6: `flag_n_o` is 1 when element 0 is active. `flag_z_o` is 1 when no element is active. `flag_c_o` is 1 when the last element is inactive. `flag_v_o` is always 0.
- R7: After reset, `done_o` is 0, `pred_o` is all zero, Z = C = 1, and N = V = 0. `done_o` pulses for one clock when a result is presented. This happens 1 clock after `start_i` is sampled in the single-pass variant, and 1 + (element count) clocks after in the iterated variant. The outputs hold until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sample operands and begin a predicate |
| op_start_i | input | 64 | Counter start value |
| op_limit_i | input | 64 | Limit value |
| wide_i | input | 1 | 1: 64-bit operands, 0: 32-bit operands |
| mode_i | input | 2 | Compare mode (R1) |
| esize_i | input | 2 | Element size (R5) |
| done_o | output | 1 | One-clock result-valid pulse |
| pred_o | output | VLEN_BITS/8 | Predicate, one bit per byte |
| flag_n_o | output | 1 | First element active |
| flag_z_o | output | 1 | No element active |
| flag_c_o | output | 1 | Last element inactive |
| flag_v_o | output | 1 | Always 0 |

## Verification
The mandated 32-bit signed case near 0x7fffffff, together with a grid of starts and limits placed at the signed and unsigned extremes of both widths, separates a correct wrap-and-reinterpret from a design that widens the counter or compares without sign. A start just under the unsigned 32-bit maximum with a lower-than limit makes the counter fail and then wrap back into range, which tells a sticky running AND apart from a per-element test. Vectors that carry random junk in bits 63:32 under 32-bit mode show that those bits are ignored. Random operands swept over all four element sizes and modes check the byte placement, the flags and the iterated latency against a reference loop.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

   typedef enum logic [1:0] {
      CMP_SLT = 2'b00,
      CMP_SLE = 2'b01,
      CMP_ULT = 2'b10,
      CMP_ULE = 2'b11
   } cmp_mode_e;

   typedef enum logic [1:0] {
      ESZ_B = 2'b00,
      ESZ_H = 2'b01,
      ESZ_W = 2'b10,
      ESZ_D = 2'b11
   } esize_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   localparam int unsigned OPW = 64;

endpackage

// File: rtl/lpg_lane_cmp.sv
// One element test: counter against limit, width and signedness selectable.
module lpg_lane_cmp
   import lpg_pkg::*;
(
   input  logic [OPW-1:0] cnt_i,
   input  logic [OPW-1:0] lim_i,
   input  logic           wide_i,
   input  cmp_mode_e      mode_i,
   output logic           pass_o
);

   logic          is_signed;
   logic          or_equal;
   logic [OPW:0]  a_ext;
   logic [OPW:0]  b_ext;
   logic          lt;
   logic          eq;

   always_comb begin
      is_signed = (mode_i == CMP_SLT) || (mode_i == CMP_SLE);
      or_equal  = (mode_i == CMP_SLE) || (mode_i == CMP_ULE);
      if (wide_i) begin
         a_ext = {is_signed & cnt_i[OPW-1], cnt_i};
         b_ext = {is_signed & lim_i[OPW-1], lim_i};
      end else begin
         a_ext = {{(OPW/2+1){is_signed & cnt_i[OPW/2-1]}}, cnt_i[OPW/2-1:0]};
         b_ext = {{(OPW/2+1){is_signed & lim_i[OPW/2-1]}}, lim_i[OPW/2-1:0]};
      end
      lt     = $signed(a_ext) < $signed(b_ext);
      eq     = (a_ext == b_ext);
      pass_o = lt | (or_equal & eq);
   end

endmodule

// File: rtl/lpg_core_flat.sv
// Single-pass core: one comparator per element slot, result registered.
module lpg_core_flat
   import lpg_pkg::*;
#(
   parameter int unsigned NLANES = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [OPW-1:0]     opa_i,
   input  logic [OPW-1:0]     lim_i,
   input  logic               wide_i,
   input  cmp_mode_e          mode_i,
   input  logic [1:0]         esize_i,
   output logic               done_o,
   output logic [NLANES-1:0]  elem_o,
   output logic [1:0]         esz_o
);

   logic [NLANES-1:0] pass;
   logic [NLANES-1:0] act;

   for (genvar e = 0; e < NLANES; e++) begin : g_lane
      logic [OPW-1:0] cnt;
      logic           in_range;
      assign cnt      = opa_i + OPW'(e);
      assign in_range = 32'(e) < (32'(NLANES) >> esize_i);

      lpg_lane_cmp u_cmp (
         .cnt_i  (cnt),
         .lim_i  (lim_i),
         .wide_i (wide_i),
         .mode_i (mode_i),
         .pass_o (pass[e])
      );

      if (e == 0) begin : g_first
         assign act[e] = pass[e] & in_range;
      end else begin : g_rest
         assign act[e] = act[e-1] & pass[e] & in_range;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o <= 1'b0;
         elem_o <= '0;
         esz_o  <= 2'b00;
      end else begin
         done_o <= start_i;
         if (start_i) begin
            elem_o <= act;
            esz_o  <= esize_i;
         end
      end
   end

   // R7: single-pass result follows the sampled start by one clock
   a_r7_flat_latency: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);

endmodule

// File: rtl/lpg_core_iter.sv
// Iterated core: one shared comparator, one element per clock.
module lpg_core_iter
   import lpg_pkg::*;
#(
   parameter int unsigned NLANES = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [OPW-1:0]     opa_i,
   input  logic [OPW-1:0]     lim_i,
   input  logic               wide_i,
   input  cmp_mode_e          mode_i,
   input  logic [1:0]         esize_i,
   output logic               done_o,
   output logic [NLANES-1:0]  elem_o,
   output logic [1:0]         esz_o
);

   localparam int unsigned IW = $clog2(NLANES);

   logic              busy;
   logic              run;
   logic [IW-1:0]     idx;
   logic [IW-1:0]     last;
   logic [OPW-1:0]    cnt;
   logic [OPW-1:0]    lim_q;
   logic              wide_q;
   cmp_mode_e         mode_q;
   logic [1:0]        esz_q;
   logic [NLANES-1:0] acc;
   logic [NLANES-1:0] acc_nx;
   logic              pass;
   logic              keep;

   lpg_lane_cmp u_cmp (
      .cnt_i  (cnt),
      .lim_i  (lim_q),
      .wide_i (wide_q),
      .mode_i (mode_q),
      .pass_o (pass)
   );

   always_comb begin
      keep        = run & pass;
      acc_nx      = acc;
      acc_nx[idx] = keep;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         run    <= 1'b0;
         idx    <= '0;
         last   <= '0;
         cnt    <= '0;
         lim_q  <= '0;
         wide_q <= 1'b0;
         mode_q <= CMP_SLT;
         esz_q  <= 2'b00;
         acc    <= '0;
         done_o <= 1'b0;
         elem_o <= '0;
         esz_o  <= 2'b00;
      end else begin
         done_o <= 1'b0;
         if (busy) begin
            acc <= acc_nx;
            run <= keep;
            cnt <= cnt + OPW'(1);
            idx <= idx + IW'(1);
            if (idx == last) begin
               busy   <= 1'b0;
               done_o <= 1'b1;
               elem_o <= acc_nx;
               esz_o  <= esz_q;
            end
         end else if (start_i) begin
            busy   <= 1'b1;
            run    <= 1'b1;
            idx    <= '0;
            last   <= IW'((NLANES >> esize_i) - 1);
            cnt    <= opa_i;
            lim_q  <= lim_i;
            wide_q <= wide_i;
            mode_q <= mode_i;
            esz_q  <= esize_i;
            acc    <= '0;
         end
      end
   end

   // R4: once the running AND drops it stays low for the rest of the pass
   a_r4_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !run) |=> (!busy || !run));

   // R7: done is a single-clock pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: rtl/lpg_place.sv
// Spreads per-element activity onto the byte-granular predicate.
module lpg_place #(
   parameter int unsigned NLANES = 16
) (
   input  logic [NLANES-1:0] elem_i,
   input  logic [1:0]        esize_i,
   output logic [NLANES-1:0] pred_o
);

   for (genvar b = 0; b < NLANES; b++) begin : g_byte
      logic [3:0] opt;
      for (genvar k = 0; k < 4; k++) begin : g_size
         if ((b % (1 << k)) == 0) begin : g_head
            assign opt[k] = elem_i[b >> k];
         end else begin : g_tail
            assign opt[k] = 1'b0;
         end
      end
      assign pred_o[b] = opt[esize_i];
   end

endmodule

// File: rtl/lpg_flags.sv
// Condition flags derived from the element predicate, all lanes governing.
module lpg_flags
   import lpg_pkg::*;
#(
   parameter int unsigned NLANES = 16
) (
   input  logic [NLANES-1:0] elem_i,
   input  logic [1:0]        esize_i,
   output flags_t            flags_o
);

   localparam int unsigned IW = $clog2(NLANES);

   logic [IW-1:0] last;

   always_comb begin
      last      = IW'((NLANES >> esize_i) - 1);
      flags_o.n = elem_i[0];
      flags_o.z = ~|elem_i;
      flags_o.c = ~elem_i[last];
      flags_o.v = 1'b0;
   end

endmodule

// File: rtl/loop_pred_gen.sv
module loop_pred_gen
   import lpg_pkg::*;
#(
   parameter int unsigned VLEN_BITS = 128,
   parameter bit          ITERATIVE = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [63:0]            op_start_i,
   input  logic [63:0]            op_limit_i,
   input  logic                   wide_i,
   input  logic [1:0]             mode_i,
   input  logic [1:0]             esize_i,
   output logic                   done_o,
   output logic [VLEN_BITS/8-1:0] pred_o,
   output logic                   flag_n_o,
   output logic                   flag_z_o,
   output logic                   flag_c_o,
   output logic                   flag_v_o
);

   localparam int unsigned NB = VLEN_BITS / 8;

   if (VLEN_BITS < 128 || (VLEN_BITS % 64) != 0) begin : g_bad_vlen
      $error("loop_pred_gen: VLEN_BITS must be a multiple of 64 and at least 128");
   end
   if ((VLEN_BITS & (VLEN_BITS - 1)) != 0) begin : g_bad_pow2
      $error("loop_pred_gen: VLEN_BITS must be a power of two");
   end

   cmp_mode_e     mode;
   logic [NB-1:0] elem;
   logic [1:0]    esz;
   flags_t        flg;

   assign mode = cmp_mode_e'(mode_i);

   if (ITERATIVE) begin : g_iter
      lpg_core_iter #(.NLANES(NB)) u_core (
         .clk     (clk),
         .rst_n   (rst_n),
         .start_i (start_i),
         .opa_i   (op_start_i),
         .lim_i   (op_limit_i),
         .wide_i  (wide_i),
         .mode_i  (mode),
         .esize_i (esize_i),
         .done_o  (done_o),
         .elem_o  (elem),
         .esz_o   (esz)
      );
   end else begin : g_flat
      lpg_core_flat #(.NLANES(NB)) u_core (
         .clk     (clk),
         .rst_n   (rst_n),
         .start_i (start_i),
         .opa_i   (op_start_i),
         .lim_i   (op_limit_i),
         .wide_i  (wide_i),
         .mode_i  (mode),
         .esize_i (esize_i),
         .done_o  (done_o),
         .elem_o  (elem),
         .esz_o   (esz)
      );
   end

   lpg_place #(.NLANES(NB)) u_place (
      .elem_i  (elem),
      .esize_i (esz),
      .pred_o  (pred_o)
   );

   lpg_flags #(.NLANES(NB)) u_flags (
      .elem_i  (elem),
      .esize_i (esz),
      .flags_o (flg)
   );

   assign flag_n_o = flg.n;
   assign flag_z_o = flg.z;
   assign flag_c_o = flg.c;
   assign flag_v_o = flg.v;

   logic [NB-1:0] head_mask;
   always_comb begin
      for (int b = 0; b < NB; b++) begin
         head_mask[b] = (b % (1 << esz)) == 0;
      end
   end

   // R4: active elements form a prefix
   a_r4_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ((elem & (elem + NB'(1))) == '0));

   // R5: bits inside an element group other than its lowest are zero
   a_r5_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_o & ~head_mask) == '0);

   // R6: first-active and none-active exclude each other
   a_r6_n_not_z: assert property (@(posedge clk) disable iff (!rst_n)
      flag_n_o |-> !flag_z_o);

   // R6: an empty predicate leaves the last element inactive
   a_r6_z_implies_c: assert property (@(posedge clk) disable iff (!rst_n)
      flag_z_o |-> flag_c_o);

endmodule

// File: tb/sim_loop_pred_gen.sv
module sim_loop_pred_gen;

   typedef struct {
      logic [15:0] pred;
      logic [3:0]  fl;
      int          lat;
      int          issue;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] opa = '0;
   logic [63:0] lim = '0;
   logic        wide = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [1:0]  esz = 2'b00;

   logic        done0, done1;
   logic [15:0] pred0, pred1;
   logic        n0, z0, c0, v0, n1, z1, c1, v1;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int pending = 0;
   bit finished = 1'b0;
   exp_t qa[$];
   exp_t qb[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   loop_pred_gen #(.VLEN_BITS(128), .ITERATIVE(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_start_i(opa), .op_limit_i(lim),
      .wide_i(wide), .mode_i(mode), .esize_i(esz), .done_o(done0), .pred_o(pred0),
      .flag_n_o(n0), .flag_z_o(z0), .flag_c_o(c0), .flag_v_o(v0));

   loop_pred_gen #(.VLEN_BITS(128), .ITERATIVE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_start_i(opa), .op_limit_i(lim),
      .wide_i(wide), .mode_i(mode), .esize_i(esz), .done_o(done1), .pred_o(pred1),
      .flag_n_o(n1), .flag_z_o(z1), .flag_c_o(c1), .flag_v_o(v1));

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Reference loop, written from the requirements
   function automatic logic [19:0] model(logic [63:0] a, logic [63:0] l, logic w,
                                         logic [1:0] m, logic [1:0] es);
      int          nl = 16 >> es;
      logic [15:0] p = '0;
      bit          alive = 1'b1;
      logic [3:0]  f;
      for (int e = 0; e < nl; e++) begin
         logic [63:0] c = a + 64'(e);
         logic [31:0] c32 = c[31:0];
         logic [31:0] l32 = l[31:0];
         bit ok;
         if (w) begin
            case (m)
               2'b00:   ok = $signed(c) <  $signed(l);
               2'b01:   ok = $signed(c) <= $signed(l);
               2'b10:   ok = c <  l;
               default: ok = c <= l;
            endcase
         end else begin
            case (m)
               2'b00:   ok = $signed(c32) <  $signed(l32);
               2'b01:   ok = $signed(c32) <= $signed(l32);
               2'b10:   ok = c32 <  l32;
               default: ok = c32 <= l32;
            endcase
         end
         alive = alive & ok;
         p[e << es] = alive;
      end
      f = {p[0], p == 16'h0, !p[(nl - 1) << es], 1'b0};
      return {f, p};
   endfunction

   task automatic apply(logic [63:0] a, logic [63:0] l, logic w, logic [1:0] m,
                        logic [1:0] es, string tag);
      logic [19:0] r = model(a, l, w, m, es);
      exp_t it;
      @(negedge clk);
      it.pred  = r[15:0];
      it.fl    = r[19:16];
      it.issue = cyc;
      it.tag   = tag;
      it.lat   = 1;
      qa.push_back(it);
      it.lat   = 1 + (16 >> es);
      qb.push_back(it);
      pending += 2;
      opa = a; lim = l; wide = w; mode = m; esz = es;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (pending != 0) @(negedge clk);
   endtask

   task automatic compare(exp_t it, logic [15:0] p, logic [3:0] f, string who);
      check(p == it.pred, {it.tag, " pred ", who}, 64'(p), 64'(it.pred));
      check(f == it.fl, {"R6 flags ", who}, 64'(f), 64'(it.fl));
      check((cyc - it.issue) == it.lat, {"R7 latency ", who},
            64'(cyc - it.issue), 64'(it.lat));
   endtask

   always @(negedge clk) begin
      if (rst_n && done0) begin
         if (qa.size() == 0) check(1'b0, "R7 spurious done u0", 64'(1), 64'(0));
         else begin compare(qa.pop_front(), pred0, {n0, z0, c0, v0}, "u0"); pending--; end
      end
      if (rst_n && done1) begin
         if (qb.size() == 0) check(1'b0, "R7 spurious done u1", 64'(1), 64'(0));
         else begin compare(qb.pop_front(), pred1, {n1, z1, c1, v1}, "u1"); pending--; end
      end
   end

   initial begin
      repeat (300000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] edges [8];
      edges[0] = 64'h0000_0000_7fff_fffd;
      edges[1] = 64'h0000_0000_ffff_fffe;
      edges[2] = 64'h0000_0000_8000_0000;
      edges[3] = 64'h7fff_ffff_ffff_fffc;
      edges[4] = 64'hffff_ffff_ffff_fffe;
      edges[5] = 64'h8000_0000_0000_0000;
      edges[6] = 64'h0000_0000_0000_0000;
      edges[7] = 64'h1234_5678_7fff_fff8;

      repeat (3) @(negedge clk);
      // R7: reset state
      check(!done0 && !done1, "R7 reset done", 64'({done0, done1}), 64'(0));
      check(pred0 == 0 && pred1 == 0, "R7 reset pred", 64'({pred0, pred1}), 64'(0));
      check({n0, z0, c0, v0} == 4'b0110, "R7 reset flags", 64'({n0, z0, c0, v0}), 64'h6);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3: mandated 32-bit signed less-or-equal wrap case, all 16 bytes active
      apply(64'h7fff_fffd, 64'h7fff_ffff, 1'b0, 2'b01, 2'b00, "R3");
      // R4: fail at element 1, then wrapped counter passes again but must stay off
      apply(64'hffff_fffe, 64'hffff_ffff, 1'b0, 2'b10, 2'b00, "R4");
      apply(64'hffff_ffff_ffff_fffe, 64'hffff_ffff_ffff_ffff, 1'b1, 2'b10, 2'b00, "R4");
      // R1: each mode on an operand pair that separates them
      for (int m = 0; m < 4; m++) begin
         apply(64'd5, 64'd10, 1'b1, 2'(m), 2'b00, "R1");
         apply(64'hffff_ffff_ffff_fff8, 64'd3, 1'b1, 2'(m), 2'b00, "R1");
      end
      // R2: junk in the upper half is ignored in 32-bit mode
      for (int k = 0; k < 40; k++) begin
         logic [31:0] lo_a = $urandom;
         logic [31:0] lo_l = lo_a + 32'($urandom_range(0, 20));
         apply({$urandom, lo_a}, {$urandom, lo_l}, 1'b0, 2'($urandom_range(0, 3)),
               2'($urandom_range(0, 3)), "R2");
      end
      // R3: boundary grid in both widths, all modes
      for (int s = 0; s < 8; s++)
         for (int t = 0; t < 8; t += 2)
            for (int m = 0; m < 4; m++)
               for (int w = 0; w < 2; w++)
                  apply(edges[s], edges[t] + 64'd3, 1'(w), 2'(m), 2'b00, "R3");
      // R5: every element size with near-limit random operands
      for (int k = 0; k < 120; k++) begin
         logic [63:0] a = {$urandom, $urandom};
         logic [63:0] d = 64'($urandom_range(0, 18));
         apply(a, (k % 3 == 0) ? {$urandom, $urandom} : a + d, 1'($urandom_range(0, 1)),
               2'($urandom_range(0, 3)), 2'(k % 4), "R5");
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule